// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block is the control sequencer a 16-bit processor core uses when it takes an interrupt and when it returns from one. The core presents its current program counter, status word and stack-pointer register. When the core reports an instruction boundary and a request arrives whose priority is higher than the running level, the sequencer saves state. It first switches to the supervisor stack if the core was in user mode. It then pushes the status word and the program counter, fetches the handler address from a vector table, and returns the new program counter, status word and stack pointer as one update.

A return command runs the reverse sequence. It pops the program counter and the status word, restores both, and swaps back to the user stack when the restored word says user mode. Every save goes onto a memory stack, so interrupts may nest to any depth. Each memory access is one request/acknowledge handshake. The block holds the saved user and saved supervisor stack pointers itself.

Top module: `intr_ctx_seq`

## Requirements
- R1: After reset, busy_o, mem_req_o and the three update strobes are low, usp_o equals USP_RST and ssp_o equals SSP_RST.
- R2: An interrupt is taken only when busy_o is low, rti_i is low, boundary_i is high, irq_req_i is high and irq_prio_i is strictly greater than psr_i[10:8]. In any other case the request has no effect and busy_o stays low on the next cycle.
- R3: On entry with psr_i[15]=1 (user mode), usp_o takes the value of r6_i on the cycle after acceptance. The working stack pointer starts from ssp_o.
- R4: On entry with psr_i[15]=0 (supervisor mode), usp_o and ssp_o are unchanged and the working stack pointer starts from r6_i.
- R5: Entry makes two writes, in this order: the captured status word to SP-1, then the captured program counter to SP-2. The final r6_o is SP-2.
- R6: After the pushes, entry reads address VEC_BASE (0x0100) plus the zero-extended 8-bit vector. The returned word becomes pc_o.
- R7: The status word written on entry has bit 15 = 0, bits 10:8 = the accepted priority, and every other bit, including the N/Z/P codes in bits 2:0, set to 0.
- R8: A return command reads the program counter from r6_i, then the status word from r6_i+1. Both are restored unchanged. If the restored bit 15 is 0, r6_o is r6_i+2.
- R9: If the restored status word has bit 15 = 1, ssp_o takes r6_i+2 in the update cycle and r6_o takes usp_o.
- R10: While mem_req_o is high and mem_ack_i is low, mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o hold their values. Each acknowledge completes exactly one access.
- R11: busy_o is high from the cycle after acceptance through the update cycle. In the update cycle pc_we_o, psr_we_o and r6_we_o pulse together for one cycle with no memory request, and busy_o is low on the cycle after.
- R12: When rti_i and a qualifying interrupt arrive in the same idle cycle, the return runs and the interrupt is dropped. rti_i and irq_req_i are ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Interrupt request |
| irq_prio_i | input | 3 | Priority of the request |
| irq_vec_i | input | 8 | Vector of the request |
| boundary_i | input | 1 | Core is at an instruction boundary |
| rti_i | input | 1 | Return-from-interrupt command |
| pc_i | input | 16 | Current program counter |
| psr_i | input | 16 | Current status word |
| r6_i | input | 16 | Current stack pointer register |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Access address |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Access completed |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| busy_o | output | 1 | Sequence in progress |
| pc_we_o | output | 1 | Program counter update strobe |
| pc_o | output | 16 | New program counter |
| psr_we_o | output | 1 | Status word update strobe |
| psr_o | output | 16 | New status word |
| r6_we_o | output | 1 | Stack pointer update strobe |
| r6_o | output | 16 | New stack pointer |
| usp_o | output | 16 | Saved user stack pointer |
| ssp_o | output | 16 | Saved supervisor stack pointer |

## Verification
A wrong privilege decision at capture shows on usp_o one cycle after acceptance, and a wrong working pointer shows on the address of the very first write. A wrong push order or decrement shows on the first two write addresses and data. Wrong status-word formation or pointer restore shows only in the single update cycle, on psr_o and r6_o. The bench carries the stack contents forward through nesting, so a corrupted save also surfaces later as wrong popped values at the matching return.

// File: rtl/ics_pkg.sv
package ics_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_PSR, S_PUSH_PC, S_VEC_RD, S_POP_PC, S_POP_PSR, S_DONE
  } ics_state_e;

  localparam int unsigned PRIV_BIT = 15;
  localparam int unsigned PRIO_LO  = 8;
endpackage

// File: rtl/ics_accept.sv
module ics_accept #(
  parameter int unsigned PRIO_W = 3
) (
  input  logic              idle_i,
  input  logic              boundary_i,
  input  logic              irq_req_i,
  input  logic [PRIO_W-1:0] irq_prio_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  input  logic              rti_i,
  output logic              take_irq_o,
  output logic              take_rti_o
);
  // return command wins over a same-cycle interrupt
  assign take_rti_o = idle_i & rti_i;
  assign take_irq_o = idle_i & ~rti_i & boundary_i & irq_req_i & (irq_prio_i > cur_prio_i);
endmodule

// File: rtl/ics_mem_if.sv
module ics_mem_if
  import ics_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned VEC_W    = 8,
  parameter logic [W-1:0] VEC_BASE = 16'h0100
) (
  input  ics_state_e       st_i,
  input  logic [W-1:0]     sp_i,
  input  logic [W-1:0]     psr_i,
  input  logic [W-1:0]     pc_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             req_o,
  output logic             we_o,
  output logic [W-1:0]     addr_o,
  output logic [W-1:0]     wdata_o
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (st_i)
      S_PUSH_PSR: begin req_o = 1'b1; we_o = 1'b1; addr_o = sp_i - ONE; wdata_o = psr_i; end
      S_PUSH_PC:  begin req_o = 1'b1; we_o = 1'b1; addr_o = sp_i - TWO; wdata_o = pc_i;  end
      S_VEC_RD:   begin req_o = 1'b1; addr_o = VEC_BASE + W'(vec_i); end
      S_POP_PC:   begin req_o = 1'b1; addr_o = sp_i; end
      S_POP_PSR:  begin req_o = 1'b1; addr_o = sp_i + ONE; end
      default: ;
    endcase
  end
endmodule

// File: rtl/intr_ctx_seq.sv
module intr_ctx_seq
  import ics_pkg::*;
#(
  parameter int unsigned  W        = 16,
  parameter int unsigned  PRIO_W   = 3,
  parameter int unsigned  VEC_W    = 8,
  parameter logic [15:0]  VEC_BASE = 16'h0100,
  parameter logic [15:0]  SSP_RST  = 16'h3000,
  parameter logic [15:0]  USP_RST  = 16'hFE00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_req_i,
  input  logic [PRIO_W-1:0] irq_prio_i,
  input  logic [VEC_W-1:0]  irq_vec_i,
  input  logic              boundary_i,
  input  logic              rti_i,
  input  logic [W-1:0]      pc_i,
  input  logic [W-1:0]      psr_i,
  input  logic [W-1:0]      r6_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [W-1:0]      mem_addr_o,
  output logic [W-1:0]      mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [W-1:0]      mem_rdata_i,
  output logic              busy_o,
  output logic              pc_we_o,
  output logic [W-1:0]      pc_o,
  output logic              psr_we_o,
  output logic [W-1:0]      psr_o,
  output logic              r6_we_o,
  output logic [W-1:0]      r6_o,
  output logic [W-1:0]      usp_o,
  output logic [W-1:0]      ssp_o
);
  localparam logic [W-1:0] TWO = W'(2);

  ics_state_e        st_q;
  logic [W-1:0]      sp_q, pc_q, psr_q, dat_q, usp_q, ssp_q;
  logic [PRIO_W-1:0] prio_q;
  logic [VEC_W-1:0]  vec_q;
  logic              rti_q;
  logic              take_irq, take_rti;
  logic [W-1:0]      psr_new;

  ics_accept #(.PRIO_W(PRIO_W)) u_accept (
    .idle_i     (st_q == S_IDLE),
    .boundary_i (boundary_i),
    .irq_req_i  (irq_req_i),
    .irq_prio_i (irq_prio_i),
    .cur_prio_i (psr_i[PRIO_LO +: PRIO_W]),
    .rti_i      (rti_i),
    .take_irq_o (take_irq),
    .take_rti_o (take_rti)
  );

  ics_mem_if #(.W(W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_mem_if (
    .st_i    (st_q),
    .sp_i    (sp_q),
    .psr_i   (psr_q),
    .pc_i    (pc_q),
    .vec_i   (vec_q),
    .req_o   (mem_req_o),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      sp_q   <= '0;
      pc_q   <= '0;
      psr_q  <= '0;
      dat_q  <= '0;
      prio_q <= '0;
      vec_q  <= '0;
      rti_q  <= 1'b0;
      usp_q  <= USP_RST;
      ssp_q  <= SSP_RST;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (take_irq) begin
            pc_q   <= pc_i;
            psr_q  <= psr_i;
            prio_q <= irq_prio_i;
            vec_q  <= irq_vec_i;
            rti_q  <= 1'b0;
            // leaving user mode: park user pointer, run on supervisor stack
            if (psr_i[PRIV_BIT]) begin
              usp_q <= r6_i;
              sp_q  <= ssp_q;
            end else begin
              sp_q  <= r6_i;
            end
            st_q <= S_PUSH_PSR;
          end else if (take_rti) begin
            sp_q  <= r6_i;
            rti_q <= 1'b1;
            st_q  <= S_POP_PC;
          end
        end
        S_PUSH_PSR: if (mem_ack_i) st_q <= S_PUSH_PC;
        S_PUSH_PC:  if (mem_ack_i) st_q <= S_VEC_RD;
        S_VEC_RD: if (mem_ack_i) begin
          dat_q <= mem_rdata_i;
          st_q  <= S_DONE;
        end
        S_POP_PC: if (mem_ack_i) begin
          dat_q <= mem_rdata_i;
          st_q  <= S_POP_PSR;
        end
        S_POP_PSR: if (mem_ack_i) begin
          psr_q <= mem_rdata_i;
          if (mem_rdata_i[PRIV_BIT]) ssp_q <= sp_q + TWO;
          st_q <= S_DONE;
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    psr_new = '0;
    psr_new[PRIO_LO +: PRIO_W] = prio_q;
  end

  assign busy_o   = (st_q != S_IDLE);
  assign pc_we_o  = (st_q == S_DONE);
  assign psr_we_o = (st_q == S_DONE);
  assign r6_we_o  = (st_q == S_DONE);
  assign pc_o     = dat_q;
  assign psr_o    = rti_q ? psr_q : psr_new;
  assign r6_o     = rti_q ? (psr_q[PRIV_BIT] ? usp_q : sp_q + TWO) : sp_q - TWO;
  assign usp_o    = usp_q;
  assign ssp_o    = ssp_q;
endmodule

// File: rtl/ics_chk.sv
module ics_chk #(
  parameter int unsigned W = 16,
  parameter int unsigned PRIO_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_req_i,
  input logic [PRIO_W-1:0] irq_prio_i,
  input logic              boundary_i,
  input logic              rti_i,
  input logic [W-1:0]      psr_i,
  input logic [W-1:0]      r6_i,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic              mem_ack_i,
  input logic              mem_we_o,
  input logic [W-1:0]      mem_addr_o,
  input logic [W-1:0]      mem_wdata_o,
  input logic              pc_we_o,
  input logic              psr_we_o,
  input logic              r6_we_o,
  input logic [W-1:0]      psr_o,
  input logic [W-1:0]      usp_o,
  input logic [W-1:0]      ssp_o
);
  p_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !rti_i && irq_req_i && (!boundary_i || irq_prio_i <= psr_i[10:8])) |=> !busy_o);

  p_usp_swap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(usp_o) |-> busy_o && $past(psr_i[15]) && usp_o == $past(r6_i));

  p_ssp_restore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ssp_o) |-> pc_we_o && psr_o[15]);

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                  && $stable(mem_wdata_o));

  p_upd_strobes_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> busy_o && psr_we_o && r6_we_o && !mem_req_o);

  p_upd_last_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |=> !busy_o);

  p_rti_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && rti_i) |=> busy_o && mem_req_o && !mem_we_o);
endmodule

bind intr_ctx_seq ics_chk u_chk (.*);

// File: tb/intr_ctx_seq_bench.sv
module intr_ctx_seq_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic irq_req = 0, boundary = 0, rti = 0, ack = 0;
  logic [2:0] prio = 0;
  logic [7:0] vec = 0;
  logic [15:0] pc = 16'h3000, psr = 16'h8002, r6 = 16'hFD00, rdata = 0;
  logic mem_req, mem_we, busy, pc_we, psr_we, r6_we;
  logic [15:0] mem_addr, mem_wdata, pc_o, psr_o, r6_o, usp_o, ssp_o;

  intr_ctx_seq u_intr_ctx_seq (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .irq_prio_i(prio), .irq_vec_i(vec),
    .boundary_i(boundary), .rti_i(rti), .pc_i(pc), .psr_i(psr), .r6_i(r6),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata), .busy_o(busy),
    .pc_we_o(pc_we), .pc_o(pc_o), .psr_we_o(psr_we), .psr_o(psr_o),
    .r6_we_o(r6_we), .r6_o(r6_o), .usp_o(usp_o), .ssp_o(ssp_o));

  int n_chk = 0, n_bad = 0, cyc = 0, wcnt = 0, wsel = 0;
  logic [15:0] mem [int];
  logic [32:0] exp_q [$];
  logic [47:0] upd_q [$];
  string tag = "R1";
  logic [15:0] m_usp = 16'hFE00, m_ssp = 16'h3000;
  bit upd_seen = 0;

  task automatic chk(bit ok, string req, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : (a ^ 16'h5A3C);
  endfunction

  // memory responder, access check, update check, watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
    if (rst_n) begin
      if (ack) ack = 0;
      else if (mem_req) begin
        if (wcnt > 0) wcnt--;
        else begin
          ack = 1;
          rdata = rd(mem_addr);
          if (mem_we) mem[int'(mem_addr)] = mem_wdata;
          if (exp_q.size() == 0) chk(0, "R10 extra access", {mem_we, mem_addr, mem_wdata}, 0);
          else begin
            logic [32:0] e;
            e = exp_q.pop_front();
            chk({mem_we, mem_addr, mem_we ? mem_wdata : 16'h0} == e, tag,
                {15'b0, mem_we, mem_addr, mem_wdata}, {15'b0, e});
          end
          wcnt = wsel % 3;
          wsel++;
        end
      end
      if (pc_we) begin
        chk(busy && psr_we && r6_we, "R11 strobes", {busy, psr_we, r6_we}, 3'b111);
        if (upd_q.size() == 0) chk(0, "R11 extra update", {pc_o, psr_o, r6_o}, 0);
        else begin
          logic [47:0] u;
          u = upd_q.pop_front();
          chk({pc_o, psr_o, r6_o} == u, tag, {pc_o, psr_o, r6_o}, u);
        end
        pc = pc_o; psr = psr_o; r6 = r6_o;
        upd_seen = 1;
      end else if (upd_seen) begin
        chk(!busy, "R11 busy end", busy, 0);
        upd_seen = 0;
      end
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic irq_op(logic [2:0] p, logic [7:0] v, bit bnd, bit noise, string t);
    bit take;
    logic [15:0] sp;
    take = bnd && (p > psr[10:8]);
    tag = t;
    if (take) begin
      sp = psr[15] ? m_ssp : r6;
      if (psr[15]) m_usp = r6;
      exp_q.push_back({1'b1, sp - 16'd1, psr});
      exp_q.push_back({1'b1, sp - 16'd2, pc});
      exp_q.push_back({1'b0, 16'h0100 + {8'h0, v}, 16'h0});
      upd_q.push_back({rd(16'h0100 + {8'h0, v}), 5'b0, p, 8'h00, sp - 16'd2});
    end
    @(negedge clk);
    irq_req = 1; prio = p; vec = v; boundary = bnd;
    @(negedge clk);
    irq_req = 0; boundary = 0;
    chk(busy == take, {t, " accept"}, busy, take);
    if (noise) begin
      irq_req = 1; prio = 7; boundary = 1; rti = 1;
      @(negedge clk);
      irq_req = 0; boundary = 0; rti = 0;
    end
    wait_idle();
    repeat (2) begin
      @(negedge clk);
      chk(!busy, {t, " no restart"}, busy, 0);
    end
    chk(usp_o == m_usp, {t, " usp"}, usp_o, m_usp);
    chk(ssp_o == m_ssp, {t, " ssp"}, ssp_o, m_ssp);
    chk(exp_q.size() == 0 && upd_q.size() == 0, {t, " seq"}, exp_q.size(), 0);
  endtask

  task automatic rti_op(bit with_irq, string t);
    logic [15:0] sp, pp, ps, nr6;
    tag = t;
    sp = r6;
    pp = rd(sp);
    ps = rd(sp + 16'd1);
    exp_q.push_back({1'b0, sp, 16'h0});
    exp_q.push_back({1'b0, sp + 16'd1, 16'h0});
    if (ps[15]) begin m_ssp = sp + 16'd2; nr6 = m_usp; end
    else nr6 = sp + 16'd2;
    upd_q.push_back({pp, ps, nr6});
    @(negedge clk);
    rti = 1;
    if (with_irq) begin irq_req = 1; prio = 7; vec = 8'h11; boundary = 1; end
    @(negedge clk);
    rti = 0; irq_req = 0; boundary = 0;
    chk(busy, {t, " start"}, busy, 1);
    wait_idle();
    chk(usp_o == m_usp, {t, " usp"}, usp_o, m_usp);
    chk(ssp_o == m_ssp, {t, " ssp"}, ssp_o, m_ssp);
    chk(exp_q.size() == 0 && upd_q.size() == 0, {t, " seq"}, exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[32'h100 + i] = 16'h4000 + 16'(i * 16);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_req, "R1 idle", {busy, mem_req}, 0);
    chk(!pc_we && !psr_we && !r6_we, "R1 strobes", {pc_we, psr_we, r6_we}, 0);
    chk(usp_o == 16'hFE00, "R1 usp", usp_o, 16'hFE00);
    chk(ssp_o == 16'h3000, "R1 ssp", ssp_o, 16'h3000);
    rst_n = 1;
    @(negedge clk);
    irq_op(3'd0, 8'h21, 1, 0, "R2 prio equal");
    irq_op(3'd3, 8'h21, 0, 0, "R2 no boundary");
    irq_op(3'd3, 8'h21, 1, 0, "R3 R5 R6 R7 user entry");
    irq_op(3'd2, 8'h40, 1, 0, "R2 lower prio");
    irq_op(3'd5, 8'h80, 1, 1, "R4 R12 supervisor entry");
    rti_op(0, "R8 return to supervisor");
    rti_op(1, "R9 R12 return to user");
    chk(pc == 16'h3000 && psr == 16'h8002 && r6 == 16'hFD00, "R9 context",
        {pc, psr, r6}, {16'h3000, 16'h8002, 16'hFD00});
    irq_op(3'd7, 8'hFF, 1, 0, "R6 top vector");
    rti_op(0, "R9 second return");
    chk(r6 == 16'hFD00 && psr == 16'h8002, "R8 restore", {r6, psr}, {16'hFD00, 16'h8002});
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule